// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block sequences the gate of one synchronous-rectifier switch from registered comparator flags that describe its drain-source voltage. It waits for a sustained negative excursion before it turns the switch on. It then holds a forced pull-up for a programmed minimum on-time and releases the gate into a high-impedance phase. In that phase a slow discharge is switched on and off with hysteresis to regulate the sensed voltage. The gate is pulled hard low when the turn-off flag fires. After each turn-off the channel stays blocked until it re-arms.

A conduction check is made on the last sample of every minimum on-time window. If no conduction is seen, the gate is released at once and the next pulse is suppressed. In a suppressed cycle the block still runs the qualification and the full on-time window, but with the gate held low. A conduction result at the end of that window allows gating again in the cycle after it, so alternate-cycle gating at the boundary load is normal behaviour. All durations are cycle counts. They are captured only while the channel is idle and armed, or while the supply is not ready.

Top module: `srg_channel`

## Requirements
- R1: While `supplyOk` is low, `gateDown` is high and the other two commands are low, with no clock edge needed. Under reset the channel is idle with `gateDown` high. The first gated cycle after the supply returns is not suppressed.
- R2: `gateUp` rises right after the clock edge that samples the (B+1)-th consecutive high `belowOn`, where B is the captured blanking count. A burst of B samples or fewer leaves the gate low and starts no on-time.
- R3: `gateUp` stays high for exactly max(M,1) cycles, where M is the captured minimum-on count. `aboveOff` is ignored during all but the last of those samples.
- R4: If `aboveOff` is low on the last on-time sample of a gated cycle, all three commands go low (high impedance) in the next cycle.
- R5: In the high-impedance phase, `gateDischarge` goes high the cycle after `aboveRegStart` is sampled high. It holds until `belowRegStop` is sampled high, and `aboveRegStart` wins when both are high.
- R6: `aboveOff` sampled high in the high-impedance phase gives `gateDown` in the next cycle.
- R7: After a turn-off, `belowOn` has no effect until re-arm. Re-arm happens when `aboveRearm` has been sampled high for D consecutive cycles (D is the captured dwell count). A low sample restarts that count.
- R8: If no dwell re-arm occurs, the channel re-arms T cycles after the turn-off edge (T is the captured timeout count). With `belowOn` held high, `gateUp` then rises T+B+1 edges after the turn-off edge.
- R9: If `aboveOff` is high on the last on-time sample, `gateDown` follows at once. The next qualified cycle keeps `gateUp` low for its whole window.
- R10: A suppressed cycle whose last on-time sample has `aboveOff` low re-enables gating for the next cycle. With `aboveOff` high on that sample, the following cycle stays suppressed.
- R11: Count inputs changed while the gate is on or blocked do not affect the cycle in progress.
- R12: At most one of `gateUp`, `gateDischarge`, `gateDown` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supplyOk | input | 1 | Supply ready; low forces pull-down and clears the sequencer |
| belowOn | input | 1 | Sensed voltage below the turn-on threshold |
| aboveOff | input | 1 | Sensed voltage above the turn-off threshold (no conduction) |
| aboveRegStart | input | 1 | Sensed voltage above the regulation start level |
| belowRegStop | input | 1 | Sensed voltage below the regulation stop level |
| aboveRearm | input | 1 | Sensed voltage above the re-arm threshold |
| motCount | input | CNT_W | Minimum on-time in cycles |
| blankCount | input | CNT_W | Turn-on blanking in cycles |
| dwellCount | input | CNT_W | Re-arm dwell in cycles |
| timeoutCount | input | CNT_W | Automatic re-arm timeout in cycles |
| gateUp | output | 1 | Strong pull-up command |
| gateDischarge | output | 1 | Slow discharge command |
| gateDown | output | 1 | Strong pull-down command |

## Verification
Each command comes from registered state, so a flag sampled at one edge shows on the outputs right after that edge. The exceptions are the turn-on qualification, which needs B+1 edges, the on-time, which lasts max(M,1) edges, and the timeout path, which takes T edges and then B+1 more. The bench drives inputs and reads outputs 2 ns after each rising edge, and it indexes every check by the number of edges since the stimulus was applied. The only combinational path is the supply-low override, and it is checked before the next edge.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic [2:0] {
    ST_ARMED,
    ST_QUAL,
    ST_ON,
    ST_REG,
    ST_REARM
  } srgState_t;

  // strobes from control to timer datapath
  typedef struct packed {
    logic mainInc;
    logic mainClr;
    logic dwellInc;
    logic latch;
  } srgStrobe_t;

  // compare results from datapath to control
  typedef struct packed {
    logic blankHit;
    logic motHit;
    logic dwellHit;
    logic timeoutHit;
  } srgFlags_t;

endpackage

// File: rtl/srg_timers.sv
module srg_timers
  import srg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  srgStrobe_t       strobe,
  input  logic [CNT_W-1:0] motCount,
  input  logic [CNT_W-1:0] blankCount,
  input  logic [CNT_W-1:0] dwellCount,
  input  logic [CNT_W-1:0] timeoutCount,
  output srgFlags_t        flags
);

  localparam int EXT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] motLat, blankLat, dwellLat, timeoutLat;
  logic [CNT_W-1:0] mainCnt, dwellCnt;
  logic [EXT_W-1:0] mainPlus, dwellPlus;

  // captured durations; reset to the longest setting so nothing fires early
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      motLat     <= CNT_MAX;
      blankLat   <= CNT_MAX;
      dwellLat   <= CNT_MAX;
      timeoutLat <= CNT_MAX;
    end else if (strobe.latch) begin
      motLat     <= motCount;
      blankLat   <= blankCount;
      dwellLat   <= dwellCount;
      timeoutLat <= timeoutCount;
    end
  end

  // shared phase counter: blanking, on-time and timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt <= '0;
    end else if (strobe.mainClr) begin
      mainCnt <= '0;
    end else if (strobe.mainInc && mainCnt != CNT_MAX) begin
      mainCnt <= mainCnt + 1'b1;
    end
  end

  // consecutive re-arm samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dwellCnt <= '0;
    end else if (!strobe.dwellInc) begin
      dwellCnt <= '0;
    end else if (dwellCnt != CNT_MAX) begin
      dwellCnt <= dwellCnt + 1'b1;
    end
  end

  assign mainPlus  = {1'b0, mainCnt} + EXT_W'(1);
  assign dwellPlus = {1'b0, dwellCnt} + EXT_W'(1);

  always_comb begin
    flags.blankHit   = (mainCnt >= blankLat);
    flags.motHit     = (mainPlus >= {1'b0, motLat});
    flags.dwellHit   = (dwellPlus >= {1'b0, dwellLat});
    flags.timeoutHit = (mainPlus >= {1'b0, timeoutLat});
  end

endmodule

// File: rtl/srg_ctrl.sv
module srg_ctrl
  import srg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       belowOn,
  input  logic       aboveOff,
  input  logic       aboveRegStart,
  input  logic       belowRegStop,
  input  logic       aboveRearm,
  input  srgFlags_t  flags,
  output srgStrobe_t strobe,
  output logic       gateUp,
  output logic       gateDischarge,
  output logic       gateDown
);

  srgState_t state, stateNxt;
  logic      skip, skipNxt;
  logic      dischg, dischgNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_ARMED;
      skip   <= 1'b0;
      dischg <= 1'b0;
    end else begin
      state  <= stateNxt;
      skip   <= skipNxt;
      dischg <= dischgNxt;
    end
  end

  always_comb begin
    stateNxt        = state;
    skipNxt         = skip;
    dischgNxt       = 1'b0;
    strobe.mainInc  = 1'b0;
    strobe.mainClr  = 1'b1;
    strobe.dwellInc = 1'b0;
    strobe.latch    = 1'b0;

    if (!supplyOk) begin
      stateNxt     = ST_ARMED;
      skipNxt      = 1'b0;
      strobe.latch = 1'b1;
    end else begin
      unique case (state)
        ST_ARMED: begin
          strobe.latch = 1'b1;
          if (belowOn) begin
            if (flags.blankHit) begin
              stateNxt = ST_ON;
            end else begin
              stateNxt       = ST_QUAL;
              strobe.mainInc = 1'b1;
              strobe.mainClr = 1'b0;
            end
          end
        end
        ST_QUAL: begin
          if (!belowOn) begin
            stateNxt = ST_ARMED;
          end else if (flags.blankHit) begin
            stateNxt = ST_ON;
          end else begin
            strobe.mainInc = 1'b1;
            strobe.mainClr = 1'b0;
          end
        end
        ST_ON: begin
          if (flags.motHit) begin
            if (aboveOff) begin
              skipNxt  = 1'b1;
              stateNxt = ST_REARM;
            end else if (skip) begin
              skipNxt  = 1'b0;
              stateNxt = ST_REARM;
            end else begin
              stateNxt = ST_REG;
            end
          end else begin
            strobe.mainInc = 1'b1;
            strobe.mainClr = 1'b0;
          end
        end
        ST_REG: begin
          if (aboveOff) begin
            stateNxt = ST_REARM;
          end else if (aboveRegStart) begin
            dischgNxt = 1'b1;
          end else if (belowRegStop) begin
            dischgNxt = 1'b0;
          end else begin
            dischgNxt = dischg;
          end
        end
        ST_REARM: begin
          strobe.dwellInc = aboveRearm;
          if ((aboveRearm && flags.dwellHit) || flags.timeoutHit) begin
            stateNxt = ST_ARMED;
          end else begin
            strobe.mainInc = 1'b1;
            strobe.mainClr = 1'b0;
          end
        end
        default: stateNxt = ST_ARMED;
      endcase
    end
  end

  assign gateUp        = supplyOk && (state == ST_ON) && !skip;
  assign gateDischarge = supplyOk && (state == ST_REG) && dischg;
  assign gateDown      = !supplyOk || (state == ST_ARMED) || (state == ST_QUAL) ||
                         (state == ST_REARM) || ((state == ST_ON) && skip);

endmodule

// File: rtl/srg_channel.sv
module srg_channel
  import srg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supplyOk,
  input  logic             belowOn,
  input  logic             aboveOff,
  input  logic             aboveRegStart,
  input  logic             belowRegStop,
  input  logic             aboveRearm,
  input  logic [CNT_W-1:0] motCount,
  input  logic [CNT_W-1:0] blankCount,
  input  logic [CNT_W-1:0] dwellCount,
  input  logic [CNT_W-1:0] timeoutCount,
  output logic             gateUp,
  output logic             gateDischarge,
  output logic             gateDown
);

  srgStrobe_t strobe;
  srgFlags_t  flags;

  srg_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .supplyOk      (supplyOk),
    .belowOn       (belowOn),
    .aboveOff      (aboveOff),
    .aboveRegStart (aboveRegStart),
    .belowRegStop  (belowRegStop),
    .aboveRearm    (aboveRearm),
    .flags         (flags),
    .strobe        (strobe),
    .gateUp        (gateUp),
    .gateDischarge (gateDischarge),
    .gateDown      (gateDown)
  );

  srg_timers #(.CNT_W(CNT_W)) tmr_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .motCount     (motCount),
    .blankCount   (blankCount),
    .dwellCount   (dwellCount),
    .timeoutCount (timeoutCount),
    .flags        (flags)
  );

endmodule

// File: rtl/srg_channel_chk.sv
module srg_channel_chk (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic belowOn,
  input logic aboveOff,
  input logic aboveRegStart,
  input logic gateUp,
  input logic gateDischarge,
  input logic gateDown
);

  // R1: supply not ready forces the pull-down alone
  a_r1_supply_low: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> (gateDown && !gateUp && !gateDischarge));

  // R2: a pull-up only starts after a sampled turn-on request
  a_r2_rise_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateUp) |-> $past(belowOn));

  // R5: regulation start seen in high impedance turns on the discharge
  a_r5_discharge_start: assert property (@(posedge clk) disable iff (!rstN)
    (!gateUp && !gateDown && supplyOk && aboveRegStart && !aboveOff)
      |=> (gateDischarge || gateDown));

  // R6: turn-off flag in high impedance gives a hard pull-down
  a_r6_turn_off: assert property (@(posedge clk) disable iff (!rstN)
    (!gateUp && !gateDown && supplyOk && aboveOff) |=> gateDown);

  // R12: never two commands together
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gateUp, gateDischarge, gateDown}));

endmodule

bind srg_channel srg_channel_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .supplyOk      (supplyOk),
  .belowOn       (belowOn),
  .aboveOff      (aboveOff),
  .aboveRegStart (aboveRegStart),
  .gateUp        (gateUp),
  .gateDischarge (gateDischarge),
  .gateDown      (gateDown)
);

// File: tb/srg_channel_tb_top.sv
module srg_channel_tb_top;

  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rstN, supplyOk, belowOn, aboveOff, aboveRegStart, belowRegStop, aboveRearm;
  logic [CNT_W-1:0] motCount, blankCount, dwellCount, timeoutCount;
  logic gateUp, gateDischarge, gateDown;

  int checks = 0;
  int errors = 0;
  bit skipExp = 0;
  int tmo = 12;

  always #10 clk = ~clk;

  srg_channel #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .belowOn(belowOn),
    .aboveOff(aboveOff), .aboveRegStart(aboveRegStart), .belowRegStop(belowRegStop),
    .aboveRearm(aboveRearm), .motCount(motCount), .blankCount(blankCount),
    .dwellCount(dwellCount), .timeoutCount(timeoutCount),
    .gateUp(gateUp), .gateDischarge(gateDischarge), .gateDown(gateDown)
  );

  // command word: up=4, discharge=2, down=1, high impedance=0
  function automatic int outWord();
    return {29'd0, gateUp, gateDischarge, gateDown};
  endfunction

  function automatic int effOn(input int m);
    return (m == 0) ? 1 : m;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    chk("R12 exclusive commands", ($countones({gateUp, gateDischarge, gateDown}) <= 1), 1);
  endtask

  // one full cycle starting from the armed state, ending armed again
  task automatic doCycle(input int b, input int m, input bit conduct, input bit perturb);
    int em;
    bit gated;
    string tag;
    em = effOn(m);
    gated = !skipExp;
    tag = gated ? "R3 gated on-time" : "R9 suppressed window";
    blankCount = CNT_W'(b);
    motCount = CNT_W'(m);
    step();
    belowOn = 1'b1;
    aboveOff = 1'b0;
    for (int k = 1; k <= b + 1 + em; k++) begin
      if (k == b + 1 + em) aboveOff = conduct ? 1'b0 : 1'b1;
      step();
      if (k <= b) chk("R2 blanking holds gate low", gateUp, 0);
      else if (k <= b + em) chk(tag, gateUp, gated ? 1 : 0);
      if (k == b + 1 && perturb) begin
        motCount = CNT_W'($urandom_range(0, 30));
        blankCount = CNT_W'($urandom_range(0, 30));
      end
    end
    if (gated && conduct) begin
      chk("R4 high impedance after on-time", outWord(), 0);
      aboveOff = 1'b1;
      step();
      chk("R6 turn-off pulls down", outWord(), 1);
    end else begin
      chk(gated ? "R9 no conduction releases gate" : "R10 suppressed cycle ends low",
          outWord(), 1);
    end
    belowOn = 1'b0;
    aboveOff = 1'b0;
    motCount = CNT_W'(m);
    blankCount = CNT_W'(b);
    repeat (tmo + 2) step();
    skipExp = !conduct;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b, m, first;
    bit conduct, prevSkip;
    void'($urandom(32'd4711));
    rstN = 1'b0; supplyOk = 1'b1; belowOn = 1'b0; aboveOff = 1'b0;
    aboveRegStart = 1'b0; belowRegStop = 1'b0; aboveRearm = 1'b0;
    blankCount = 10'd3; motCount = 10'd5; dwellCount = 10'd4; timeoutCount = CNT_W'(tmo);
    #25;
    chk("R1 reset pulls down", outWord(), 1);
    rstN = 1'b1;
    step(); step();
    chk("R1 idle after reset", outWord(), 1);

    // R2: a burst of exactly the blanking length is ignored
    belowOn = 1'b1;
    repeat (3) begin step(); chk("R2 short burst ignored", gateUp, 0); end
    belowOn = 1'b0;
    step();
    chk("R2 short burst left gate low", outWord(), 1);

    // R4/R5/R6: into regulation, then exercise the discharge hysteresis
    belowOn = 1'b1;
    for (int k = 1; k <= 4 + 5; k++) begin
      if (k < 9) aboveOff = 1'b1; else aboveOff = 1'b0;
      step();
      if (k == 4) chk("R2 turn-on at blank+1", gateUp, 1);
      if (k > 4 && k < 9) chk("R3 turn-off flag ignored in on-time", gateUp, 1);
    end
    chk("R4 high impedance", outWord(), 0);
    aboveRegStart = 1'b1; step();
    chk("R5 discharge starts", outWord(), 2);
    aboveRegStart = 1'b0; step();
    chk("R5 discharge holds", outWord(), 2);
    belowRegStop = 1'b1; aboveRegStart = 1'b1; step();
    chk("R5 start wins over stop", outWord(), 2);
    aboveRegStart = 1'b0; step();
    chk("R5 discharge stops", outWord(), 0);
    belowRegStop = 1'b0;
    aboveOff = 1'b1; step();
    chk("R6 hard off", outWord(), 1);
    aboveOff = 1'b0;

    // R7: blocked until a full dwell of re-arm samples
    repeat (3) begin step(); chk("R7 request ignored while blocked", gateUp, 0); end
    aboveRearm = 1'b1;
    repeat (3) step();
    aboveRearm = 1'b0; step();
    aboveRearm = 1'b1;
    repeat (3) begin step(); chk("R7 broken dwell keeps block", gateUp, 0); end
    step();
    aboveRearm = 1'b0;
    repeat (3) begin step(); chk("R7 qualification after re-arm", gateUp, 0); end
    step();
    chk("R7 gate rises after dwell re-arm", gateUp, 1);
    repeat (5) step();
    aboveOff = 1'b1; step(); aboveOff = 1'b0;

    // R8: timeout re-arm with the request held high all the time
    first = -1;
    for (int k = 1; k <= 400 && first < 0; k++) begin
      step();
      if (gateUp) first = k;
    end
    chk("R8 timeout re-arm latency", first, tmo + 3 + 1);
    repeat (5) step();
    aboveOff = 1'b1; step(); aboveOff = 1'b0;
    belowOn = 1'b0;
    repeat (tmo + 2) step();

    // R1: supply drop during on-time, then clean restart
    belowOn = 1'b1;
    repeat (4) step();
    chk("R1 gate on before supply drop", gateUp, 1);
    supplyOk = 1'b0;
    #1;
    chk("R1 supply low forces pull-down", outWord(), 1);
    step();
    chk("R1 supply low held", outWord(), 1);
    supplyOk = 1'b1; belowOn = 1'b0;
    step(); step();
    skipExp = 0;

    // R9/R10: directed skip, stay-skipped, recovery
    doCycle(2, 4, 1'b0, 1'b0);
    doCycle(2, 4, 1'b0, 1'b0);
    doCycle(2, 4, 1'b1, 1'b0);
    chk("R10 recovered to gating", skipExp, 0);
    doCycle(0, 0, 1'b1, 1'b0);

    // random cycles, with count inputs disturbed mid-cycle (R11)
    for (int i = 0; i < 40; i++) begin
      b = $urandom_range(0, 6);
      m = $urandom_range(0, 8);
      conduct = ($urandom_range(0, 2) != 0);
      prevSkip = skipExp;
      doCycle(b, m, conduct, 1'b1);
      if (prevSkip) chk("R10 skip state follows end-of-window check", skipExp, conduct ? 0 : 1);
      else chk("R11 cycle unaffected by count changes", skipExp, conduct ? 0 : 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule